// File: doc/BRIEF.md
# Multiplexed Serial ADC Host Controller

This block sits on the system side of an eight-input multiplexed serial ADC whose single chip-select line also starts each conversion. A client hands it a request over a valid/ready handshake. Each request carries a seven-bit channel setting: single-ended or differential, odd/sign, a two-bit pair address, common-return use, unipolar or bipolar coding, and a sleep request. The controller raises the select line to start a sample and waits out the conversion time. It then pulls the line low and runs a 16-pulse serial clock burst. During the burst it shifts the new setting out on the data-in wire and shifts the finished sample in from the data-out wire.

The converter applies a setting one conversion late: the setting sent during a transfer governs the next sample. The controller keeps track of this. Each returned result carries the setting that produced it, a flag telling whether that setting is known, and a coding tag (two's complement or straight binary). Between transfers it enforces an acquisition gap. After a sleep request it enforces a much longer wake-up gap. A mode input, captured with each request, chooses between a short start pulse and holding the select line high for the whole conversion.

Top module: `adcx_host`

## Requirements
- R1: After reset the select line and the serial clock are low, `resValid` is low and `reqReady` is high.
- R2: An accepted request (`reqValid` and `reqReady` high at a clock edge) drives the select line high on that edge and drops `reqReady` until the result has been delivered.
- R3: With the captured mode 1 (hold) the select line stays high for exactly CONV_CYCLES clocks. With mode 0 (short) it stays high for exactly SHORT_CYCLES clocks. In both modes the first serial clock rise comes CONV_CYCLES + CLK_DIV clocks after the select line rises.
- R4: The serial clock is low whenever the select line is high. Each transfer has exactly FRAME_BITS (16) clock pulses, each high for CLK_DIV system clocks.
- R5: The data-in wire carries the request setting MSB first in the bit order SD (bit 6), OS (bit 5), S1 (bit 4), S0 (bit 3), COM (bit 2), UNI (bit 1), SLP (bit 0), followed by zeros up to 16 bits. It changes only on falling serial clock edges.
- R6: The data-out wire is sampled at each rising serial clock edge, with the first sample the result MSB. `resData` holds all 16 samples in arrival order.
- R7: `resValid` is a one-clock pulse in the clock where the serial clock falls for the 16th time.
- R8: `resCfg` is the setting sent in the previous transfer. `resBipolar` is 1 when that setting's UNI bit (bit 1) is 0.
- R9: The first result after reset has `resCfgOk` = 0 and `resCfg` = 0. Every later result has `resCfgOk` = 1.
- R10: After a transfer whose SLP bit (bit 0) is 0, `reqReady` rises exactly ACQ_CYCLES clocks after the `resValid` pulse.
- R11: After a transfer whose SLP bit is 1, `reqReady` rises exactly WAKE_CYCLES clocks after the `resValid` pulse.
- R12: `holdMode` is captured when a request is accepted. A change during the conversion has no effect on the select pulse width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Controller can accept a request |
| reqCfg | input | 7 | Channel setting {SD,OS,S1,S0,COM,UNI,SLP} |
| holdMode | input | 1 | 1: hold the select line high through the conversion; 0: short start pulse |
| adcCs | output | 1 | Combined chip-select / convert-start line |
| adcSck | output | 1 | Serial clock, idle low |
| adcSdi | output | 1 | Setting bits to the converter |
| adcSdo | input | 1 | Result bits from the converter |
| resValid | output | 1 | One-clock result strobe |
| resData | output | FRAME_BITS | Captured result word |
| resCfg | output | 7 | Setting that produced this result |
| resCfgOk | output | 1 | `resCfg` is known (low only for the first result) |
| resBipolar | output | 1 | Result is two's complement (1) or straight binary (0) |

## Verification
The select line rises on the clock edge that accepts a request. It falls SHORT_CYCLES or CONV_CYCLES clocks later, depending on the mode. The first serial clock rise comes CONV_CYCLES + CLK_DIV clocks after the select line rises. The result strobe appears in the clock of the 16th falling serial clock edge, and ready returns exactly ACQ_CYCLES or WAKE_CYCLES clocks after that strobe. The bench samples on falling system clock edges and counts those edges from each event to the next. It reads its sideband monitor counters only once the hold-off has elapsed, well after they have settled. Every one of the 128 settings is swept in both modes against a converter model whose sample word encodes the setting it received and the conversion index.

// File: rtl/adcx_pkg.sv
package adcx_pkg;

  localparam int CFG_W   = 7;
  localparam int CFG_UNI = 1;
  localparam int CFG_SLP = 0;

  typedef logic [CFG_W-1:0] cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CONV,
    ST_XFER
  } state_t;

  // Strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic loadTx;   // request accepted: load setting into transmit shifter
    logic sample;   // serial clock about to rise: capture data-out
    logic shift;    // serial clock about to fall: advance data-in
    logic finish;   // last falling edge: publish result
  } strobe_t;

endpackage

// File: rtl/adcx_ctrl.sv
module adcx_ctrl
  import adcx_pkg::*;
#(
  parameter int CLK_DIV      = 2,
  parameter int CONV_CYCLES  = 175,
  parameter int SHORT_CYCLES = 3,
  parameter int ACQ_CYCLES   = 75,
  parameter int WAKE_CYCLES  = 3000000,
  parameter int FRAME_BITS   = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  output logic    reqReady,
  input  logic    reqSlp,
  input  logic    holdMode,
  output logic    adcCs,
  output logic    adcSck,
  output strobe_t strobe
);

  localparam int HOLD_MAX = (WAKE_CYCLES > ACQ_CYCLES) ? WAKE_CYCLES : ACQ_CYCLES;
  localparam int HOLD_W   = $clog2(HOLD_MAX + 1);
  localparam int CONV_W   = $clog2(CONV_CYCLES + 1);
  localparam int DIV_W    = $clog2(CLK_DIV + 1);
  localparam int BIT_W    = $clog2(FRAME_BITS + 1);

  localparam logic [HOLD_W-1:0] HOLD_ACQ   = HOLD_W'(ACQ_CYCLES);
  localparam logic [HOLD_W-1:0] HOLD_WAKE  = HOLD_W'(WAKE_CYCLES);
  localparam logic [HOLD_W-1:0] HOLD_TOP   = HOLD_W'(HOLD_MAX);
  localparam logic [CONV_W-1:0] CONV_LAST  = CONV_W'(CONV_CYCLES - 1);
  localparam logic [CONV_W-1:0] SHORT_LAST = CONV_W'(SHORT_CYCLES - 1);
  localparam logic [DIV_W-1:0]  DIV_LAST   = DIV_W'(CLK_DIV - 1);
  localparam logic [BIT_W-1:0]  BIT_LAST   = BIT_W'(FRAME_BITS - 1);

  state_t            state;
  logic [CONV_W-1:0] convCnt;
  logic [DIV_W-1:0]  divCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [HOLD_W-1:0] holdCnt;
  logic              curHold;
  logic              curSlp;
  logic              accept;
  logic              halfDone;

  assign reqReady = (state == ST_IDLE) && (holdCnt == '0);
  assign accept   = reqValid && reqReady;
  assign halfDone = (state == ST_XFER) && (divCnt == DIV_LAST);

  always_comb begin
    strobe        = '0;
    strobe.loadTx = accept;
    strobe.sample = halfDone && !adcSck;
    strobe.shift  = halfDone && adcSck;
    strobe.finish = halfDone && adcSck && (bitCnt == BIT_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      adcCs   <= 1'b0;
      adcSck  <= 1'b0;
      convCnt <= '0;
      divCnt  <= '0;
      bitCnt  <= '0;
      holdCnt <= '0;
      curHold <= 1'b0;
      curSlp  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (holdCnt != '0) holdCnt <= holdCnt - 1'b1;
          if (accept) begin
            adcCs   <= 1'b1;
            convCnt <= '0;
            curHold <= holdMode;
            curSlp  <= reqSlp;
            state   <= ST_CONV;
          end
        end
        ST_CONV: begin
          convCnt <= convCnt + 1'b1;
          if (!curHold && convCnt == SHORT_LAST) adcCs <= 1'b0;
          if (convCnt == CONV_LAST) begin
            adcCs  <= 1'b0;
            divCnt <= '0;
            bitCnt <= '0;
            state  <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (halfDone) begin
            divCnt <= '0;
            adcSck <= !adcSck;
            if (adcSck) begin
              bitCnt <= bitCnt + 1'b1;
              if (bitCnt == BIT_LAST) begin
                state   <= ST_IDLE;
                holdCnt <= curSlp ? HOLD_WAKE : HOLD_ACQ;
              end
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertion support and checks ----------------
  logic [CONV_W-1:0] csHighCnt;
  logic [HOLD_W-1:0] gapCnt;
  logic              lastSlp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csHighCnt <= '0;
      gapCnt    <= HOLD_TOP;
      lastSlp   <= 1'b0;
    end else begin
      csHighCnt <= adcCs ? csHighCnt + 1'b1 : '0;
      if (strobe.finish) begin
        gapCnt  <= '0;
        lastSlp <= curSlp;
      end else if (gapCnt != HOLD_TOP) begin
        gapCnt <= gapCnt + 1'b1;
      end
    end
  end

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (adcCs && !reqReady));

  assert_cs_width_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(adcCs) |-> (csHighCnt == (curHold ? CONV_W'(CONV_CYCLES) : CONV_W'(SHORT_CYCLES))));

  assert_sck_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    adcCs |-> !adcSck);

  assert_holdoff_R10_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcCs) |-> (gapCnt >= (lastSlp ? HOLD_WAKE : HOLD_ACQ)));

endmodule

// File: rtl/adcx_dpath.sv
module adcx_dpath
  import adcx_pkg::*;
#(
  parameter int FRAME_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strobe,
  input  cfg_t                  reqCfg,
  input  logic                  adcSdo,
  output logic                  adcSdi,
  output logic                  resValid,
  output logic [FRAME_BITS-1:0] resData,
  output cfg_t                  resCfg,
  output logic                  resCfgOk,
  output logic                  resBipolar
);

  localparam int PAD_W = FRAME_BITS - CFG_W;

  logic [FRAME_BITS-1:0] txShift;
  logic [FRAME_BITS-1:0] rxShift;
  cfg_t                  curCfg;
  cfg_t                  prevCfg;
  logic                  havePrev;

  assign adcSdi = txShift[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift    <= '0;
      rxShift    <= '0;
      curCfg     <= '0;
      prevCfg    <= '0;
      havePrev   <= 1'b0;
      resValid   <= 1'b0;
      resData    <= '0;
      resCfg     <= '0;
      resCfgOk   <= 1'b0;
      resBipolar <= 1'b0;
    end else begin
      resValid <= strobe.finish;
      if (strobe.loadTx) begin
        txShift <= {reqCfg, {PAD_W{1'b0}}};
        curCfg  <= reqCfg;
      end else if (strobe.shift) begin
        txShift <= {txShift[FRAME_BITS-2:0], 1'b0};
      end
      if (strobe.sample) rxShift <= {rxShift[FRAME_BITS-2:0], adcSdo};
      if (strobe.finish) begin
        resData    <= rxShift;
        resCfg     <= prevCfg;
        resCfgOk   <= havePrev;
        resBipolar <= !prevCfg[CFG_UNI];
        prevCfg    <= curCfg;
        havePrev   <= 1'b1;
      end
    end
  end

  // ---------------- assertion support and checks ----------------
  logic resSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resSeen <= 1'b0;
    else if (resValid) resSeen <= 1'b1;
  end

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  assert_first_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (resCfgOk == resSeen));

endmodule

// File: rtl/adcx_host.sv
module adcx_host
  import adcx_pkg::*;
#(
  parameter int CLK_DIV      = 2,
  parameter int CONV_CYCLES  = 175,
  parameter int SHORT_CYCLES = 3,
  parameter int ACQ_CYCLES   = 75,
  parameter int WAKE_CYCLES  = 3000000,
  parameter int FRAME_BITS   = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic [CFG_W-1:0]      reqCfg,
  input  logic                  holdMode,
  output logic                  adcCs,
  output logic                  adcSck,
  output logic                  adcSdi,
  input  logic                  adcSdo,
  output logic                  resValid,
  output logic [FRAME_BITS-1:0] resData,
  output logic [CFG_W-1:0]      resCfg,
  output logic                  resCfgOk,
  output logic                  resBipolar
);

  strobe_t strobe;

  adcx_ctrl #(
    .CLK_DIV(CLK_DIV), .CONV_CYCLES(CONV_CYCLES), .SHORT_CYCLES(SHORT_CYCLES),
    .ACQ_CYCLES(ACQ_CYCLES), .WAKE_CYCLES(WAKE_CYCLES), .FRAME_BITS(FRAME_BITS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqSlp(reqCfg[CFG_SLP]), .holdMode(holdMode),
    .adcCs(adcCs), .adcSck(adcSck), .strobe(strobe)
  );

  adcx_dpath #(.FRAME_BITS(FRAME_BITS)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqCfg(reqCfg),
    .adcSdo(adcSdo), .adcSdi(adcSdi), .resValid(resValid), .resData(resData),
    .resCfg(resCfg), .resCfgOk(resCfgOk), .resBipolar(resBipolar)
  );

endmodule

// File: tb/sim_adcx_host.sv
`timescale 1ns/1ps
module sim_adcx_host;

  localparam int CLK_DIV = 2;
  localparam int CONV    = 20;
  localparam int SHORT   = 3;
  localparam int ACQ     = 10;
  localparam int WAKE    = 300;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [6:0]  reqCfg = '0;
  logic        holdMode = 1'b1;
  logic        adcCs, adcSck, adcSdi, adcSdo;
  logic        resValid;
  logic [15:0] resData;
  logic [6:0]  resCfg;
  logic        resCfgOk, resBipolar;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  adcx_host #(
    .CLK_DIV(CLK_DIV), .CONV_CYCLES(CONV), .SHORT_CYCLES(SHORT),
    .ACQ_CYCLES(ACQ), .WAKE_CYCLES(WAKE), .FRAME_BITS(16)
  ) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqCfg(reqCfg), .holdMode(holdMode), .adcCs(adcCs), .adcSck(adcSck),
    .adcSdi(adcSdi), .adcSdo(adcSdo), .resValid(resValid), .resData(resData),
    .resCfg(resCfg), .resCfgOk(resCfgOk), .resBipolar(resBipolar)
  );

  // ---------------- converter model ----------------
  logic [15:0] outReg = '0;
  logic [15:0] inReg  = '0;
  logic [6:0]  rxCfg  = '0;
  logic [8:0]  rxTail = '0;
  int          inCnt  = 0;
  int          convIdx = 0;

  assign adcSdo = outReg[15];

  always @(posedge adcCs) begin
    outReg  <= {rxCfg, 9'(convIdx)};
    convIdx = convIdx + 1;
  end

  always @(negedge adcSck) outReg <= {outReg[14:0], 1'b0};

  always @(posedge adcSck) begin
    inReg = {inReg[14:0], adcSdi};
    inCnt = inCnt + 1;
    if (inCnt == 16) begin
      rxCfg  = inReg[15:9];
      rxTail = inReg[8:0];
      inCnt  = 0;
    end
  end

  // ---------------- serial clock monitor ----------------
  int   sckBad = 0, pulses = 0, hiRun = 0, csAge = 0, firstRise = -1;
  logic prevCs = 1'b0, prevSck = 1'b0;

  always @(negedge clk) begin
    if (adcCs && !prevCs) begin
      pulses = 0; csAge = 0; firstRise = -1;
    end else begin
      csAge = csAge + 1;
    end
    if (adcCs && adcSck) sckBad = sckBad + 1;
    if (adcSck && !prevSck && pulses == 0 && firstRise < 0) firstRise = csAge;
    if (adcSck) hiRun = hiRun + 1;
    else if (hiRun != 0) begin
      if (hiRun != CLK_DIV) sckBad = sckBad + 1;
      pulses = pulses + 1;
      hiRun = 0;
    end
    prevCs  = adcCs;
    prevSck = adcSck;
  end

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  logic [6:0] lastSent = '0;
  int         reqIdx = 0;

  task automatic runReq(input logic [6:0] cfg, input logic mode);
    int width;
    int wait0;
    logic [15:0] expData;
    while (!reqReady) @(negedge clk);
    reqCfg   = cfg;
    holdMode = mode;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    holdMode = !mode;              // R12: late change must not matter
    chk(adcCs && !reqReady, "R2 start/busy", {adcCs, reqReady}, 2);
    width = 0;
    while (adcCs) begin width++; @(negedge clk); end
    chk(width == (mode ? CONV : SHORT), "R3/R12 select width", width, mode ? CONV : SHORT);
    while (!resValid) begin
      chk(!reqReady, "R2 busy until result", reqReady, 0);
      @(negedge clk);
    end
    expData = {(reqIdx == 0) ? 7'd0 : lastSent, 9'(reqIdx)};
    chk(resData == expData, "R6 result word", resData, expData);
    chk(resCfg == ((reqIdx == 0) ? 7'd0 : lastSent), "R8 result setting", resCfg,
        (reqIdx == 0) ? 0 : lastSent);
    chk(resCfgOk == (reqIdx != 0), "R9 setting known flag", resCfgOk, reqIdx != 0);
    if (reqIdx != 0)
      chk(resBipolar == !lastSent[1], "R8 coding tag", resBipolar, !lastSent[1]);
    chk(!adcSck, "R7 strobe with last falling edge", adcSck, 0);
    wait0 = 0;
    while (!reqReady) begin wait0++; @(negedge clk); end
    if (cfg[0]) chk(wait0 == WAKE, "R11 wake hold-off", wait0, WAKE);
    else        chk(wait0 == ACQ, "R10 acquisition hold-off", wait0, ACQ);
    chk(pulses == 16, "R4 pulse count", pulses, 16);
    chk(sckBad == 0, "R4 clock shape/idle", sckBad, 0);
    chk(firstRise == CONV + CLK_DIV, "R3 first clock rise", firstRise, CONV + CLK_DIV);
    chk(rxCfg == cfg, "R5 setting on data-in", rxCfg, cfg);
    chk(rxTail == 9'd0, "R5 trailing zeros", rxTail, 0);
    lastSent = cfg;
    reqIdx++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!adcCs && !adcSck && !resValid, "R1 reset outputs", {adcCs, adcSck, resValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !adcCs && !adcSck && !resValid, "R1 idle after reset",
        {reqReady, adcCs, adcSck, resValid}, 8);
    for (int m = 1; m >= 0; m--)
      for (int c = 0; c < 128; c++)
        runReq(7'(c ^ (m ? 0 : 7'h55)), m[0]);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", reqIdx, 256);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule